// File: doc/BRIEF.md
# Serial Display Frame Loader

This block takes display frames over a two-wire serial link, a data clock and a data line, and stores them in an 8-row by 60-column display memory. Each frame is 68 bits long. The first 60 bits are a column word and the last 8 bits are a command byte. The command byte picks the multiplex ratio, column-only operation, a target row and a forced on/off state. It can also request a row-scan restart.

There is no select or latch line. A frame takes effect when the data clock has stayed low for longer than a programmable number of system clocks. The data clock and data line are sampled as ordinary synchronous inputs on a fast system clock. Every bit is also passed on through a cascade output with a fixed delay, so several loaders can share one link.

The row scan reads the memory through a registered read port. The command state appears on registered outputs.

Top module: `serial_frame_loader`

## Requirements
- R1: While `rst` is high, and after it drops, these outputs are zero: `mux_code`, `col_only`, `blank_on`, `set_on`, `sync_req`, `sdata_out`. Every memory row also reads back as zero.
- R2: A bit is taken from `sdata_in` on each falling edge of `sclk_in`. In a 68-bit frame, the first bit shifted lands in memory bit 59 and the 60th bit lands in bit 0. The last 8 bits form the command byte, and the very last bit shifted is command bit 0.
- R3: A frame is committed only after `sclk_in` has been low for `STROBE_CYCLES` system clocks. A low phase shorter than that, in the middle of a frame, commits nothing.
- R4: There is at most one commit per low phase. A commit happens only if at least one bit has been shifted since the previous commit. A held-low data clock therefore yields exactly one `sync_req` pulse for one synchronize frame.
- R5: Command bits 1:0 set `mux_code`: 00 means 2 rows, 10 means 4 rows, 11 means 8 rows. The reserved code 01 leaves `mux_code` unchanged.
- R6: Command bits 5:3 give the target row. The row number is masked to the row count of the multiplex ratio that results from the same command: 1 bit for 2 rows, 2 bits for 4 rows, 3 bits for 8 rows.
- R7: `col_only` takes the value of command bit 2 at each commit.
- R8: Command bits 7:6 set the forced state:
  - 01 gives `blank_on`=1.
  - 10 gives `set_on`=1.
  - 00 clears both.
  - 11 clears both, raises `sync_req` for exactly one cycle, and writes nothing to memory.
- R9: A commit that follows fewer than 68 shifted bits updates the command outputs but leaves the memory untouched.
- R10: After each falling edge of `sclk_in`, `sdata_out` holds the bit taken 67 edges earlier, or 0 if fewer bits have been taken since reset. A downstream loader sampling it at its next edge therefore sees the stream delayed by 68 data-clock periods.
- R11: `rd_data` shows the memory row selected by `rd_addr` one system clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_in | input | 1 | Serial data clock |
| sdata_in | input | 1 | Serial data input |
| rd_addr | input | 3 | Row selected for reading |
| sdata_out | output | 1 | Delayed serial data for the next loader |
| mux_code | output | 2 | Current multiplex code |
| col_only | output | 1 | Column-only operation selected |
| blank_on | output | 1 | All columns forced off |
| set_on | output | 1 | All columns forced on |
| sync_req | output | 1 | One-cycle row-scan restart request |
| rd_data | output | 60 | Registered memory row |

## Verification
The hardest case to reach is a low phase in the middle of a frame that comes close to the strobe limit without reaching it. A premature commit would leave no trace in memory, because fewer than 68 bits have been shifted at that point.

To make such a commit visible, the stimulus places the byte 8'hC0 in the column data so that it is the last eight bits shifted when the long gap opens. A premature commit would then decode as a synchronize request. The bench counts `sync_req` pulses across the whole frame and expects none.

A synchronize frame followed by a data clock held low for several strobe times checks that exactly one commit occurs per low phase.

// File: rtl/sfl_pkg.sv
package sfl_pkg;

  typedef struct packed {
    logic       force_on;
    logic       force_off;
    logic [2:0] row;
    logic       col_only;
    logic [1:0] mux;
  } cmd_t;

  localparam logic [1:0] MUX_2    = 2'b00;
  localparam logic [1:0] MUX_RSVD = 2'b01;
  localparam logic [1:0] MUX_4    = 2'b10;
  localparam logic [1:0] MUX_8    = 2'b11;

  function automatic logic [2:0] row_mask(input logic [1:0] m);
    case (m)
      MUX_4:   row_mask = 3'b011;
      MUX_8:   row_mask = 3'b111;
      default: row_mask = 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/sfl_sampler.sv
module sfl_sampler (
  input  logic clk,
  input  logic rst,
  input  logic sclk_in,
  input  logic sdata_in,
  output logic sclk_lvl,
  output logic sdata_lvl,
  output logic fall_evt
);
  logic sclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_lvl  <= 1'b0;
      sclk_prev <= 1'b0;
      sdata_lvl <= 1'b0;
    end else begin
      sclk_lvl  <= sclk_in;
      sclk_prev <= sclk_lvl;
      sdata_lvl <= sdata_in;
    end
  end

  assign fall_evt = sclk_prev & ~sclk_lvl;
endmodule

// File: rtl/sfl_shifter.sv
module sfl_shifter #(
  parameter int FRAME_BITS = 68
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  fall_evt,
  input  logic                  bit_in,
  input  logic                  commit,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  pending,
  output logic                  full_frame
);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_BITS);

  logic [CNT_W-1:0] cnt, cnt_base, cnt_nxt;

  always_comb begin
    cnt_base = commit ? '0 : cnt;
    cnt_nxt  = cnt_base;
    if (fall_evt && cnt_base != CNT_MAX) cnt_nxt = cnt_base + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame <= '0;
      cnt   <= '0;
    end else begin
      cnt <= cnt_nxt;
      if (fall_evt) frame <= {frame[FRAME_BITS-2:0], bit_in};
    end
  end

  assign pending    = (cnt != '0);
  assign full_frame = (cnt == CNT_MAX);
endmodule

// File: rtl/sfl_strobe.sv
module sfl_strobe #(
  parameter int STROBE_CYCLES = 1600
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_lvl,
  input  logic pending,
  output logic commit
);
  localparam int LIM_W = $clog2(STROBE_CYCLES + 1);
  localparam logic [LIM_W-1:0] LIMIT = LIM_W'(STROBE_CYCLES);

  logic [LIM_W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || sclk_lvl) low_cnt <= '0;
    else if (low_cnt != LIMIT) low_cnt <= low_cnt + 1'b1;
  end

  assign commit = ~sclk_lvl & pending & (low_cnt == LIMIT - 1'b1);
endmodule

// File: rtl/sfl_store.sv
module sfl_store
  import sfl_pkg::*;
#(
  parameter int COLS     = 60,
  parameter int CMD_BITS = 8,
  parameter int ROWS     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         commit,
  input  logic                         full_frame,
  input  logic [COLS+CMD_BITS-1:0]     frame,
  input  logic [$clog2(ROWS)-1:0]      rd_addr,
  output logic [1:0]                   mux_code,
  output logic                         col_only,
  output logic                         blank_on,
  output logic                         set_on,
  output logic                         sync_req,
  output logic [COLS-1:0]              rd_data
);
  localparam int ADDR_W = $clog2(ROWS);

  cmd_t              cmd;
  logic [COLS-1:0]   col_word;
  logic              is_sync;
  logic [1:0]        mux_nxt;
  logic [ADDR_W-1:0] wr_row;
  logic              wr_en;
  logic [COLS-1:0]   mem [ROWS];

  assign cmd      = cmd_t'(frame[CMD_BITS-1:0]);
  assign col_word = frame[COLS+CMD_BITS-1:CMD_BITS];
  assign is_sync  = cmd.force_on & cmd.force_off;
  assign mux_nxt  = (cmd.mux == MUX_RSVD) ? mux_code : cmd.mux;
  assign wr_row   = ADDR_W'(cmd.row & row_mask(mux_nxt));
  assign wr_en    = commit & full_frame & ~is_sync;

  always_ff @(posedge clk) begin
    if (rst) begin
      mux_code <= MUX_2;
      col_only <= 1'b0;
      blank_on <= 1'b0;
      set_on   <= 1'b0;
      sync_req <= 1'b0;
    end else begin
      sync_req <= commit & is_sync;
      if (commit) begin
        mux_code <= mux_nxt;
        col_only <= cmd.col_only;
        blank_on <= cmd.force_off & ~is_sync;
        set_on   <= cmd.force_on & ~is_sync;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) mem[r] <= '0;
      rd_data <= '0;
    end else begin
      if (wr_en) mem[wr_row] <= col_word;
      rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/serial_frame_loader.sv
module serial_frame_loader #(
  parameter int COLS          = 60,
  parameter int CMD_BITS      = 8,
  parameter int ROWS          = 8,
  parameter int STROBE_CYCLES = 1600
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    sclk_in,
  input  logic                    sdata_in,
  input  logic [$clog2(ROWS)-1:0] rd_addr,
  output logic                    sdata_out,
  output logic [1:0]              mux_code,
  output logic                    col_only,
  output logic                    blank_on,
  output logic                    set_on,
  output logic                    sync_req,
  output logic [COLS-1:0]         rd_data
);
  localparam int FRAME_BITS = COLS + CMD_BITS;

  logic                  sclk_lvl, sdata_lvl, fall_evt;
  logic                  commit, pending, full_frame;
  logic [FRAME_BITS-1:0] frame;

  sfl_sampler u_sampler (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .sclk_lvl(sclk_lvl), .sdata_lvl(sdata_lvl), .fall_evt(fall_evt)
  );

  sfl_shifter #(.FRAME_BITS(FRAME_BITS)) u_shifter (
    .clk(clk), .rst(rst), .fall_evt(fall_evt), .bit_in(sdata_lvl),
    .commit(commit), .frame(frame), .pending(pending), .full_frame(full_frame)
  );

  sfl_strobe #(.STROBE_CYCLES(STROBE_CYCLES)) u_strobe (
    .clk(clk), .rst(rst), .sclk_lvl(sclk_lvl), .pending(pending), .commit(commit)
  );

  sfl_store #(.COLS(COLS), .CMD_BITS(CMD_BITS), .ROWS(ROWS)) u_store (
    .clk(clk), .rst(rst), .commit(commit), .full_frame(full_frame),
    .frame(frame), .rd_addr(rd_addr), .mux_code(mux_code),
    .col_only(col_only), .blank_on(blank_on), .set_on(set_on),
    .sync_req(sync_req), .rd_data(rd_data)
  );

  assign sdata_out = frame[FRAME_BITS-1];
endmodule

// File: rtl/serial_frame_loader_chk.sv
module serial_frame_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       sclk_in,
  input logic       sdata_out,
  input logic [1:0] mux_code,
  input logic       blank_on,
  input logic       set_on,
  input logic       sync_req
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (mux_code == 2'b00 && !blank_on && !set_on && !sync_req && !sdata_out));

  a_r8_sync_single: assert property (@(posedge clk) disable iff (rst)
    sync_req |=> !sync_req);

  a_r8_force_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(blank_on && set_on));

  a_r5_no_reserved_code: assert property (@(posedge clk) disable iff (rst)
    mux_code != 2'b01);

  a_r3_commit_while_low: assert property (@(posedge clk) disable iff (rst)
    sync_req |-> (!$past(sclk_in, 2) && !$past(sclk_in, 3)));

  a_r10_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata_out) |-> (!$past(sclk_in, 2) && $past(sclk_in, 3)));
endmodule

bind serial_frame_loader serial_frame_loader_chk u_chk (
  .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_out(sdata_out),
  .mux_code(mux_code), .blank_on(blank_on), .set_on(set_on),
  .sync_req(sync_req)
);

// File: tb/tb_serial_frame_loader.sv
module tb_serial_frame_loader;
  localparam int STROBE = 40;
  localparam int HI = 4;
  localparam int LO = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk_in = 1'b0;
  logic sdata_in = 1'b0;
  logic [2:0] rd_addr = 3'd0;
  logic sdata_out, col_only, blank_on, set_on, sync_req;
  logic [1:0] mux_code;
  logic [59:0] rd_data;

  int checks = 0;
  int failures = 0;
  int sync_cnt = 0;
  int fall_n = 0;
  bit hist [0:4095];

  always #2.5 clk = ~clk;

  serial_frame_loader #(.STROBE_CYCLES(STROBE)) dut (
    .clk(clk), .rst(rst), .sclk_in(sclk_in), .sdata_in(sdata_in),
    .rd_addr(rd_addr), .sdata_out(sdata_out), .mux_code(mux_code),
    .col_only(col_only), .blank_on(blank_on), .set_on(set_on),
    .sync_req(sync_req), .rd_data(rd_data)
  );

  always @(negedge clk) if (sync_req) sync_cnt++;

  // {frame[67:0] = {col60, cmd8}, exp_mux[1:0], exp_row[2:0], exp_col, exp_blank, exp_set}
  localparam logic [75:0] VEC [6] = '{
    {60'hA5A5A5A5A5A5A5A, 8'b00_011_0_11, 2'b11, 3'd3, 1'b0, 1'b0, 1'b0},
    {60'h123456789ABCDEF, 8'b01_111_1_11, 2'b11, 3'd7, 1'b1, 1'b1, 1'b0},
    {60'h0F0F0F0F0F0F0F0, 8'b10_110_0_10, 2'b10, 3'd2, 1'b0, 1'b0, 1'b1},
    {60'hFFF000FFF000FFF, 8'b00_101_0_00, 2'b00, 3'd1, 1'b0, 1'b0, 1'b0},
    {60'h800000000000001, 8'b00_010_1_01, 2'b00, 3'd0, 1'b1, 1'b0, 1'b0},
    {60'h5555555555AAAAA, 8'b00_000_0_11, 2'b11, 3'd0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    int idx;
    @(negedge clk);
    sclk_in = 1'b1;
    sdata_in = b;
    repeat (HI) @(negedge clk);
    sclk_in = 1'b0;
    fall_n++;
    hist[fall_n] = b;
    repeat (LO) @(negedge clk);
    idx = fall_n - 67;
    // R10: cascade output holds the bit taken 67 falls earlier
    chk("R10 sdata_out", 64'(sdata_out), (idx > 0) ? 64'(hist[idx]) : 64'd0);
  endtask

  task automatic send_frame(input logic [67:0] f, input int n, input int gap_after, input int gap_len);
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(f[i]);
      if (n - i == gap_after) repeat (gap_len) @(negedge clk);
    end
  endtask

  task automatic strobe();
    repeat (STROBE + 10) @(negedge clk);
  endtask

  task automatic read_row(input logic [2:0] r, output logic [59:0] d);
    @(negedge clk);
    rd_addr = r;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    sclk_in = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    fall_n = 0;
    for (int i = 0; i < 4096; i++) hist[i] = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [59:0] d, keep, gcol;
    logic [67:0] f;
    do_reset();
    sync_cnt = 0;

    // R1: reset state
    chk("R1 mux_code", 64'(mux_code), 64'd0);
    chk("R1 flags", 64'({col_only, blank_on, set_on, sync_req, sdata_out}), 64'd0);
    read_row(3'd0, d); chk("R1 row0", 64'(d), 64'd0);
    read_row(3'd7, d); chk("R1 row7", 64'(d), 64'd0);

    // Table walk: R2, R5, R6, R7, R8
    for (int v = 0; v < 6; v++) begin
      f = VEC[v][75:8];
      send_frame(f, 68, 0, 0);
      strobe();
      chk("R5 mux_code", 64'(mux_code), 64'(VEC[v][7:6]));
      chk("R7 col_only", 64'(col_only), 64'(VEC[v][2]));
      chk("R8 blank_on", 64'(blank_on), 64'(VEC[v][1]));
      chk("R8 set_on", 64'(set_on), 64'(VEC[v][0]));
      read_row(VEC[v][5:3], d);
      chk("R2 R6 row content", 64'(d), 64'(f[67:8]));
    end

    // R11: back-to-back reads, one cycle latency each
    read_row(3'd3, d); chk("R11 row3", 64'(d), 64'(VEC[0][75:16]));
    read_row(3'd7, d); chk("R11 row7", 64'(d), 64'(VEC[1][75:16]));

    // R9: command-only 8-bit load updates command, not memory
    read_row(3'd0, keep);
    send_frame({60'd0, 8'b01_000_0_11}, 8, 0, 0);
    strobe();
    chk("R9 blank_on", 64'(blank_on), 64'd1);
    read_row(3'd0, d); chk("R9 row0 untouched", 64'(d), 64'(keep));

    // R3: long mid-frame gap below limit, sync pattern placed to expose a false commit
    gcol = 60'hC0 << 30;
    sync_cnt = 0;
    send_frame({gcol, 8'b00_100_0_11}, 68, 30, STROBE - 8);
    strobe();
    chk("R3 no early commit", 64'(sync_cnt), 64'd0);
    read_row(3'd4, d); chk("R3 row4", 64'(d), 64'(gcol));
    chk("R3 blank cleared", 64'(blank_on), 64'd0);

    // R4, R8: synchronize frame, clock held low a long time
    sync_cnt = 0;
    send_frame({60'hFFFFFFFFFFFFFFF, 8'b11_100_0_11}, 68, 0, 0);
    repeat (3 * STROBE) @(negedge clk);
    chk("R4 single sync pulse", 64'(sync_cnt), 64'd1);
    chk("R8 sync clears forces", 64'({blank_on, set_on}), 64'd0);
    read_row(3'd4, d); chk("R8 sync no write", 64'(d), 64'(gcol));

    // R1: reset after activity
    do_reset();
    chk("R1 mux after reset", 64'(mux_code), 64'd0);
    chk("R1 sdata_out after reset", 64'(sdata_out), 64'd0);
    read_row(3'd3, d); chk("R1 row3 cleared", 64'(d), 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule